// File: doc/BRIEF.md
# Keyboard and Display Register Port

This block sits on a simple byte-wide processor bus and gives software a polled (or interrupt-driven) path to a character source and a character sink. On the source side, a one-cycle valid pulse delivers an 8-bit ASCII code. The code is latched, and an input-ready flag rises. On the sink side, the block emits a one-cycle strobe with the character and then waits for a ready indication before it accepts the next one.

Software sees six byte registers. Each channel has a data register, a status register and a control register. The ready flags are handshakes driven by side effects of bus accesses:
- Reading the keyboard data register consumes the character and lowers the input-ready flag.
- Writing the display data register hands off a character and lowers the output-ready flag.

Each channel can raise an interrupt request when its flag is set and its enable bit is on. The two requests are merged onto one output.

Reads are combinational: `bus_rdata` reflects the addressed register while `bus_rd` is high, and any side effect takes place at the clock edge that ends the access. The external reset is asynchronous, active low, and is released synchronously inside the block.

Top module: `kbd_disp_port`

## Requirements
- R1: After reset all status, control and data registers read 0x00, `irq` is low and `char_stb` is low.
- R2: A `key_vld` pulse stores `key_code` in the keyboard data register (offset 0x00) and sets the input-ready flag, bit 1 of the keyboard status register (offset 0x04), at the same clock edge.
- R3: A read of offset 0x00 returns the stored code and clears the input-ready flag at that edge. If a key arrives in the same cycle as the read, the read returns the old code, and the new code is stored with the flag left at 1.
- R4: A key arriving while input-ready is 1 (and not being read in that cycle) overwrites the data and sets a sticky overrun bit, bit 7 of the keyboard status register. A read of the keyboard status register returns it set and clears it at that edge.
- R5: The output-ready flag, bit 2 of the display status register (offset 0x14), is 0 after reset and becomes 1 at the clock edge where `disp_rdy` is sampled high.
- R6: A write to the display data register (offset 0x10) while output-ready is 1 puts the byte on `char_out` and pulses `char_stb` for exactly one cycle after the write edge. It also clears output-ready to 0.
- R7: A write to offset 0x10 while output-ready is 0 is dropped: no strobe, and `char_out` is unchanged.
- R8: Bit 1 of each control register (keyboard 0x08, display 0x18) is that channel's interrupt enable, and it reads back as written. Status bit 0 equals the channel's ready flag ANDed with its enable. `irq` is the OR of the two status bit-0 values.
- R9: Unused status and control bits read as 0. Writes to the status registers have no effect. Reads of unmapped offsets return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Register byte offset |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while bus_rd is high |
| key_vld | input | 1 | Character-valid pulse from the keyboard source |
| key_code | input | 8 | ASCII code accompanying key_vld |
| disp_rdy | input | 1 | Display sink can take a character |
| char_stb | output | 1 | One-cycle character-out strobe |
| char_out | output | 8 | Character presented to the display sink |
| irq | output | 1 | Merged interrupt request |

## Verification
The bench targets the collision between a key arrival and a data read in the same cycle. A design that gave the clear priority would lose the new character's flag, and one that read the wrong register version would return the new code.

It also checks the following:
- Overrun is raised only when a flag that is still set gets overwritten, and it survives until a status read. A design that cleared it on a data read, or never set it, fails the status read-back.
- A display write made while output-ready is low must produce no strobe. A design that accepted it would emit a spurious character.
- Masked control bits must not read back.
- Writes to status must not disturb the flags, which a loosely decoded register would do.

// File: rtl/kdp_pkg.sv
package kdp_pkg;
  localparam int BYTE_W = 8;

  // Byte offsets on the bus (software contract)
  localparam int OFF_KDATA = 'h00;
  localparam int OFF_KSTAT = 'h04;
  localparam int OFF_KCTRL = 'h08;
  localparam int OFF_DDATA = 'h10;
  localparam int OFF_DSTAT = 'h14;
  localparam int OFF_DCTRL = 'h18;

  // Bit positions inside status and control bytes
  localparam int BIT_IRQ  = 0;
  localparam int BIT_KIN  = 1;
  localparam int BIT_DOUT = 2;
  localparam int BIT_OVR  = 7;
  localparam int BIT_IE   = 1;
endpackage

// File: rtl/kdp_key_chan.sv
module kdp_key_chan #(
  parameter int DATA_W = kdp_pkg::BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_vld,
  input  logic [DATA_W-1:0] key_code,
  input  logic              data_rd,
  input  logic              stat_rd,
  input  logic              ie_wr,
  input  logic              ie_val,
  output logic [DATA_W-1:0] data_q,
  output logic              kin_q,
  output logic              ovr_q,
  output logic              ie_q,
  output logic              irq_o
);
  logic kin_d, ovr_d, ie_d;
  logic flag_en;

  // Next-state: arrival wins over the read-side clear
  always_comb begin
    kin_d = kin_q;
    ovr_d = ovr_q;
    ie_d  = ie_wr ? ie_val : ie_q;
    if (data_rd) kin_d = 1'b0;
    if (stat_rd) ovr_d = 1'b0;
    if (key_vld) begin
      kin_d = 1'b1;
      if (kin_q && !data_rd) ovr_d = 1'b1;
    end
  end

  assign flag_en = key_vld | data_rd | stat_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      kin_q  <= 1'b0;
      ovr_q  <= 1'b0;
      ie_q   <= 1'b0;
    end else begin
      if (key_vld) data_q <= key_code;
      if (flag_en) begin
        kin_q <= kin_d;
        ovr_q <= ovr_d;
      end
      if (ie_wr) ie_q <= ie_d;
    end
  end

  assign irq_o = kin_q & ie_q;

  AST_KIN_ON_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    key_vld |=> kin_q); // R2
  AST_KIN_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && !key_vld) |=> !kin_q); // R3
  AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (key_vld && kin_q && !data_rd) |=> ovr_q); // R4
  AST_OVR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_q && !stat_rd) |=> ovr_q); // R4
endmodule

// File: rtl/kdp_disp_chan.sv
module kdp_disp_chan #(
  parameter int DATA_W = kdp_pkg::BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              disp_rdy,
  input  logic              data_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              ie_wr,
  input  logic              ie_val,
  output logic              dout_q,
  output logic              ie_q,
  output logic              irq_o,
  output logic              stb_q,
  output logic [DATA_W-1:0] char_q
);
  logic accept;
  logic dout_d;
  logic dout_en;

  assign accept  = data_wr & dout_q;
  assign dout_en = accept | disp_rdy;

  always_comb begin
    dout_d = dout_q;
    if (accept)        dout_d = 1'b0;
    else if (disp_rdy) dout_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= 1'b0;
      ie_q   <= 1'b0;
      stb_q  <= 1'b0;
      char_q <= '0;
    end else begin
      stb_q <= accept;
      if (dout_en) dout_q <= dout_d;
      if (accept)  char_q <= wdata;
      if (ie_wr)   ie_q   <= ie_val;
    end
  end

  assign irq_o = dout_q & ie_q;

  AST_DOUT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_rdy && !data_wr) |=> dout_q); // R5
  AST_DOUT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && dout_q) |=> (!dout_q && stb_q)); // R6
  AST_STB_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q |=> !stb_q); // R6
  AST_BLOCKED_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !dout_q) |=> (!stb_q && $stable(char_q))); // R7
endmodule

// File: rtl/kbd_disp_port.sv
module kbd_disp_port #(
  parameter int ADDR_W      = 5,
  parameter int DATA_W      = kdp_pkg::BYTE_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              key_vld,
  input  logic [DATA_W-1:0] key_code,
  input  logic              disp_rdy,
  output logic              char_stb,
  output logic [DATA_W-1:0] char_out,
  output logic              irq
);
  import kdp_pkg::*;

  localparam logic [ADDR_W-1:0] A_KDATA = ADDR_W'(OFF_KDATA);
  localparam logic [ADDR_W-1:0] A_KSTAT = ADDR_W'(OFF_KSTAT);
  localparam logic [ADDR_W-1:0] A_KCTRL = ADDR_W'(OFF_KCTRL);
  localparam logic [ADDR_W-1:0] A_DDATA = ADDR_W'(OFF_DDATA);
  localparam logic [ADDR_W-1:0] A_DSTAT = ADDR_W'(OFF_DSTAT);
  localparam logic [ADDR_W-1:0] A_DCTRL = ADDR_W'(OFF_DCTRL);

  // Reset: asserted asynchronously, released through a flop chain
  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_s_n = rst_pipe[SYNC_STAGES-1];

  // Decode
  logic kd_rd, ks_rd, kc_wr, dd_wr, dc_wr;
  assign kd_rd = bus_rd & (bus_addr == A_KDATA);
  assign ks_rd = bus_rd & (bus_addr == A_KSTAT);
  assign kc_wr = bus_wr & (bus_addr == A_KCTRL);
  assign dd_wr = bus_wr & (bus_addr == A_DDATA);
  assign dc_wr = bus_wr & (bus_addr == A_DCTRL);

  logic [DATA_W-1:0] k_data;
  logic              k_kin, k_ovr, k_ie, k_irq;
  logic              d_dout, d_ie, d_irq;

  kdp_key_chan #(.DATA_W(DATA_W)) u_key (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .key_vld  (key_vld),
    .key_code (key_code),
    .data_rd  (kd_rd),
    .stat_rd  (ks_rd),
    .ie_wr    (kc_wr),
    .ie_val   (bus_wdata[BIT_IE]),
    .data_q   (k_data),
    .kin_q    (k_kin),
    .ovr_q    (k_ovr),
    .ie_q     (k_ie),
    .irq_o    (k_irq)
  );

  kdp_disp_chan #(.DATA_W(DATA_W)) u_disp (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .disp_rdy (disp_rdy),
    .data_wr  (dd_wr),
    .wdata    (bus_wdata),
    .ie_wr    (dc_wr),
    .ie_val   (bus_wdata[BIT_IE]),
    .dout_q   (d_dout),
    .ie_q     (d_ie),
    .irq_o    (d_irq),
    .stb_q    (char_stb),
    .char_q   (char_out)
  );

  // Read mux: unused bits and unmapped offsets give zero
  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (bus_addr)
        A_KDATA: bus_rdata = k_data;
        A_KSTAT: begin
          bus_rdata[BIT_OVR] = k_ovr;
          bus_rdata[BIT_KIN] = k_kin;
          bus_rdata[BIT_IRQ] = k_irq;
        end
        A_KCTRL: bus_rdata[BIT_IE] = k_ie;
        A_DDATA: bus_rdata = char_out;
        A_DSTAT: begin
          bus_rdata[BIT_DOUT] = d_dout;
          bus_rdata[BIT_IRQ]  = d_irq;
        end
        A_DCTRL: bus_rdata[BIT_IE] = d_ie;
        default: bus_rdata = '0;
      endcase
    end
  end

  assign irq = k_irq | d_irq;

  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_s_n)
    irq |-> ((k_kin && k_ie) || (d_dout && d_ie))); // R8
endmodule

// File: tb/kbd_disp_port_test.sv
`timescale 1ns/1ps
module kbd_disp_port_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [4:0] bus_addr;
  logic       bus_rd, bus_wr;
  logic [7:0] bus_wdata, bus_rdata;
  logic       key_vld;
  logic [7:0] key_code;
  logic       disp_rdy;
  logic       char_stb;
  logic [7:0] char_out;
  logic       irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  kbd_disp_port uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .key_vld(key_vld), .key_code(key_code), .disp_rdy(disp_rdy),
    .char_stb(char_stb), .char_out(char_out), .irq(irq)
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp,
                     input string req, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic key(input logic [7:0] c);
    @(negedge clk);
    key_vld = 1'b1; key_code = c;
    @(negedge clk);
    key_vld = 1'b0;
  endtask

  task automatic ready_pulse();
    @(negedge clk);
    disp_rdy = 1'b1;
    @(negedge clk);
    disp_rdy = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk({7'd0, irq}, 8'h00, "R1", "irq after reset");
    chk({7'd0, char_stb}, 8'h00, "R1", "char_stb after reset");
    rd(5'h04, d); chk(d, 8'h00, "R1", "kbd status");
    rd(5'h08, d); chk(d, 8'h00, "R1", "kbd ctrl");
    rd(5'h14, d); chk(d, 8'h00, "R1", "disp status");
    rd(5'h00, d); chk(d, 8'h00, "R1", "kbd data");
  endtask

  task automatic t_key_basic();
    logic [7:0] d;
    key(8'h61);
    rd(5'h04, d); chk(d, 8'h02, "R2", "KIN set after key");
    rd(5'h00, d); chk(d, 8'h61, "R3", "kbd data code");
    rd(5'h04, d); chk(d, 8'h00, "R3", "KIN cleared by data read");
  endtask

  task automatic t_key_collide();
    logic [7:0] d;
    key(8'h31);
    @(negedge clk);
    bus_addr = 5'h00; bus_rd = 1'b1; key_vld = 1'b1; key_code = 8'h32;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0; key_vld = 1'b0;
    chk(d, 8'h31, "R3", "colliding read returns old code");
    rd(5'h04, d); chk(d, 8'h02, "R3", "KIN kept, no overrun on collision");
    rd(5'h00, d); chk(d, 8'h32, "R3", "new code stored on collision");
  endtask

  task automatic t_overrun();
    logic [7:0] d;
    key(8'h41);
    key(8'h42);
    rd(5'h00, d); chk(d, 8'h42, "R4", "overrun overwrites data");
    rd(5'h04, d); chk(d, 8'h80, "R4", "overrun bit sticky past data read");
    rd(5'h04, d); chk(d, 8'h00, "R4", "overrun cleared by status read");
  endtask

  task automatic t_kbd_irq();
    logic [7:0] d;
    wr(5'h08, 8'hFF);
    rd(5'h08, d); chk(d, 8'h02, "R8", "kbd ctrl reads only enable");
    chk({7'd0, irq}, 8'h00, "R8", "irq low with KIN=0");
    key(8'h5A);
    rd(5'h04, d); chk(d, 8'h03, "R8", "kbd status irq bit");
    chk({7'd0, irq}, 8'h01, "R8", "irq high with KIN and enable");
    wr(5'h04, 8'h00);
    rd(5'h04, d); chk(d, 8'h03, "R9", "status write ignored");
    rd(5'h0C, d); chk(d, 8'h00, "R9", "unmapped offset reads zero");
    rd(5'h00, d);
    chk({7'd0, irq}, 8'h00, "R8", "irq drops after data read");
    wr(5'h08, 8'h00);
  endtask

  task automatic t_disp();
    logic [7:0] d;
    wr(5'h10, 8'h55);
    chk({7'd0, char_stb}, 8'h00, "R7", "no strobe when DOUT=0");
    chk(char_out, 8'h00, "R7", "char_out unchanged on dropped write");
    ready_pulse();
    rd(5'h14, d); chk(d, 8'h04, "R5", "DOUT set after ready");
    @(negedge clk);
    bus_addr = 5'h10; bus_wdata = 8'h48; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    chk({7'd0, char_stb}, 8'h01, "R6", "strobe after accepted write");
    chk(char_out, 8'h48, "R6", "char_out value");
    @(negedge clk);
    chk({7'd0, char_stb}, 8'h00, "R6", "strobe lasts one cycle");
    rd(5'h14, d); chk(d, 8'h00, "R6", "DOUT cleared by write");
    wr(5'h18, 8'h02);
    chk({7'd0, irq}, 8'h00, "R8", "disp irq masked while DOUT=0");
    ready_pulse();
    rd(5'h14, d); chk(d, 8'h05, "R8", "disp status irq bit");
    chk({7'd0, irq}, 8'h01, "R8", "irq from display channel");
    wr(5'h14, 8'h00);
    rd(5'h14, d); chk(d, 8'h05, "R9", "disp status write ignored");
    rd(5'h18, d); chk(d, 8'h02, "R8", "disp ctrl readback");
  endtask

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_rd = 1'b0; bus_wr = 1'b0;
    bus_wdata = '0; key_vld = 1'b0; key_code = '0; disp_rdy = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_key_basic();
    t_key_collide();
    t_overrun();
    t_kbd_irq();
    t_disp();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule